// File: doc/BRIEF.md
# Synthesiser Loop Divider and Phase Comparator

This block is the digital heart of a frequency-synthesiser phase-locked loop. A fixed divider turns reference ticks into a comparison-rate event. A programmable divider turns prescaled RF ticks into a divided-RF event. A two-flip-flop phase/frequency detector compares the two events and produces pump-up and pump-down pulses for an external analog charge pump. A lock detector watches the width of those pulses and raises a lock flag once the loop has settled.

Everything runs on one fast system clock. The reference and prescaled RF clocks arrive as one-cycle tick strobes. Four configuration bits control the loop:

- a charge-pump current select;
- a pump kill that silences both pump outputs;
- a drive-amplifier shut-off;
- a test route that puts the comparison-rate and divided-RF waveforms on two general-purpose port pins in place of their latched values.

With a 512:1 reference division, the synthesised frequency is the divider ratio times 8 (the external prescaler) times the comparison rate.

Top module: `synthLoopCore`

## Requirements
- R1: While reset is held, pumpUp, pumpDown and lockFlag are 0, and portP6 and portP7 equal portLatch[0] and portLatch[1].
- R2: The reference divider issues one comparison event every REF_DIV reference ticks (512 by default). With the test route on, portP6 carries this rate, high for the first REF_DIV/2 ticks of each period and low for the rest.
- R3: The programmable divider issues one divided-RF event every `ratio` RF ticks. With the test route on, portP7 rises once per divided period.
- R4: A ratio below MIN_RATIO (8) is treated as MIN_RATIO.
- R5: A new ratio value does not disturb the divided period in progress. It takes effect at the next reload.
- R6: A comparison event sets the up flag and a divided-RF event sets the down flag. In the cycle after both flags are high, both clear. After reset, the first comparison event raises pumpUp on the REF_DIV-th reference tick.
- R7: While pumpKill is 1, pumpUp and pumpDown are both 0, whatever the detector state.
- R8: currentHigh equals currentSel (1 selects the high pump current). ampEnable is the inverse of ampKill.
- R9: With testRoute at 1, portP6 shows the comparison waveform and portP7 shows the divided-RF waveform. With testRoute at 0, both follow portLatch.
- R10: Each time both detector flags are high, the pulse just ended is scored. The score counts the reference ticks during which either flag was high. lockFlag rises after LOCK_COUNT (4) consecutive pulses scoring at most PULSE_LIMIT (16). lockFlag clears as soon as a pulse exceeds PULSE_LIMIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe per reference clock period |
| rfTick | input | 1 | One-cycle strobe per prescaled RF period |
| ratio | input | 15 | Programmable divider ratio |
| currentSel | input | 1 | Pump current select, 1 = high |
| pumpKill | input | 1 | 1 silences both pump outputs |
| testRoute | input | 1 | 1 routes comparator inputs to the port pins |
| ampKill | input | 1 | 1 disables the drive amplifier |
| portLatch | input | 2 | Latched values for portP6 (bit 0) and portP7 (bit 1) |
| pumpUp | output | 1 | Charge-pump up pulse |
| pumpDown | output | 1 | Charge-pump down pulse |
| currentHigh | output | 1 | High pump current selected |
| ampEnable | output | 1 | Drive-amplifier enable |
| lockFlag | output | 1 | Loop locked |
| portP6 | output | 1 | Port pin 6 value |
| portP7 | output | 1 | Port pin 7 value |

## Verification
The assertions assume that the ticks are single-cycle strobes and that the divided-RF rate stays well below the system clock. They also assume that testRoute is held steady across the cycles they compare, so a pin edge comes only from the divider and not from a change of source. The stimulus keeps refTick high every cycle and drives rfTick at a fixed spacing of one to three cycles. It changes ratio or tick spacing only while the period monitor is idle, or just after a divided-period edge. It changes testRoute only outside the port-edge measurements. The lock model is fed only from the pump outputs while pumpKill is 0.

// File: rtl/synthLoopPkg.sv
package synthLoopPkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic pumpGate;   // pump outputs allowed
    logic routeTest;  // comparator inputs onto port pins
  } ctrlStrobe_t;

  // Raw detector flags, datapath to control
  typedef struct packed {
    logic upRaw;
    logic dnRaw;
  } pfdState_t;

endpackage

// File: rtl/synthLoopDatapath.sv
module synthLoopDatapath
  import synthLoopPkg::*;
#(
  parameter int REF_DIV   = 512,
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               rfTick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [1:0]         portLatch,
  input  ctrlStrobe_t        ctrl,
  output pfdState_t          pfd,
  output logic               pumpUp,
  output logic               pumpDown,
  output logic               portP6,
  output logic               portP7
);

  localparam int REF_W = $clog2(REF_DIV);
  localparam logic [REF_W-1:0]   REF_LAST = REF_W'(REF_DIV - 1);
  localparam logic [REF_W-1:0]   REF_HALF = REF_W'(REF_DIV / 2);
  localparam logic [RATIO_W-1:0] RATIO_MIN = RATIO_W'(MIN_RATIO);

  // Reference divider
  logic [REF_W-1:0] refCnt;
  logic             refEdge;
  logic             refLevel;

  assign refEdge  = refTick && (refCnt == REF_LAST);
  assign refLevel = refCnt < REF_HALF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (refTick) begin
      refCnt <= refEdge ? '0 : refCnt + 1'b1;
    end
  end

  // Programmable divider, reloads at terminal count
  logic [RATIO_W-1:0] effRatio;
  logic [RATIO_W-1:0] curRatio;
  logic [RATIO_W-1:0] divCnt;
  logic               divEdge;
  logic               divLevel;

  assign effRatio = (ratio < RATIO_MIN) ? RATIO_MIN : ratio;
  assign divEdge  = rfTick && (divCnt == '0);
  assign divLevel = divCnt >= (curRatio >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      curRatio <= RATIO_MIN;
    end else if (rfTick) begin
      if (divCnt == '0) begin
        divCnt   <= effRatio - 1'b1;
        curRatio <= effRatio;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  // Two-flip-flop phase/frequency detector
  logic upQ;
  logic dnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (upQ && dnQ) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upQ | refEdge;
      dnQ <= dnQ | divEdge;
    end
  end

  assign pfd.upRaw = upQ;
  assign pfd.dnRaw = dnQ;
  assign pumpUp    = upQ & ctrl.pumpGate;
  assign pumpDown  = dnQ & ctrl.pumpGate;

  // Port pin source selection
  logic [1:0] testSrc;
  logic [1:0] portOut;
  assign testSrc = {divLevel, refLevel};

  for (genvar i = 0; i < 2; i++) begin : g_portMux
    assign portOut[i] = ctrl.routeTest ? testSrc[i] : portLatch[i];
  end

  assign portP6 = portOut[0];
  assign portP7 = portOut[1];

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < curRatio);  // R3

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    divEdge |=> curRatio >= RATIO_MIN);  // R4

  AST_TEST_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.routeTest && $past(ctrl.routeTest) && $rose(portP6)) |-> (refCnt == '0 && $past(refEdge)));  // R9

endmodule

// File: rtl/synthLoopControl.sv
module synthLoopControl
  import synthLoopPkg::*;
#(
  parameter int LOCK_COUNT  = 4,
  parameter int PULSE_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        currentSel,
  input  logic        pumpKill,
  input  logic        testRoute,
  input  logic        ampKill,
  input  pfdState_t   pfd,
  output ctrlStrobe_t ctrl,
  output logic        currentHigh,
  output logic        ampEnable,
  output logic        lockFlag
);

  localparam int WIDTH_W = $clog2(PULSE_LIMIT + 2);
  localparam int GOOD_W  = $clog2(LOCK_COUNT + 1);
  localparam logic [WIDTH_W-1:0] LIMIT_V   = WIDTH_W'(PULSE_LIMIT);
  localparam logic [GOOD_W-1:0]  GOOD_FULL = GOOD_W'(LOCK_COUNT);
  localparam logic [GOOD_W-1:0]  GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  // Configuration decode
  assign ctrl.pumpGate  = !pumpKill;
  assign ctrl.routeTest = testRoute;
  assign currentHigh    = currentSel;
  assign ampEnable      = !ampKill;

  // Lock detector
  logic               bothHigh;
  logic               anyHigh;
  logic               widthOver;
  logic [WIDTH_W-1:0] widthCnt;
  logic [GOOD_W-1:0]  goodCnt;
  logic               lockQ;

  assign bothHigh  = pfd.upRaw & pfd.dnRaw;
  assign anyHigh   = pfd.upRaw | pfd.dnRaw;
  assign widthOver = widthCnt > LIMIT_V;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthCnt <= '0;
      goodCnt  <= '0;
      lockQ    <= 1'b0;
    end else if (bothHigh) begin
      widthCnt <= '0;
      if (!widthOver) begin
        if (goodCnt >= GOOD_LAST) begin
          goodCnt <= GOOD_FULL;
          lockQ   <= 1'b1;
        end else begin
          goodCnt <= goodCnt + 1'b1;
        end
      end else begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end
    end else begin
      if (anyHigh && refTick && !widthOver) begin
        widthCnt <= widthCnt + 1'b1;
      end
      if (widthOver) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end
    end
  end

  assign lockFlag = lockQ;

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(bothHigh));  // R10

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    widthOver |=> !lockQ);  // R10

endmodule

// File: rtl/synthLoopCore.sv
module synthLoopCore
  import synthLoopPkg::*;
#(
  parameter int REF_DIV     = 512,
  parameter int RATIO_W     = 15,
  parameter int MIN_RATIO   = 8,
  parameter int LOCK_COUNT  = 4,
  parameter int PULSE_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               rfTick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               currentSel,
  input  logic               pumpKill,
  input  logic               testRoute,
  input  logic               ampKill,
  input  logic [1:0]         portLatch,
  output logic               pumpUp,
  output logic               pumpDown,
  output logic               currentHigh,
  output logic               ampEnable,
  output logic               lockFlag,
  output logic               portP6,
  output logic               portP7
);

  ctrlStrobe_t ctrl;
  pfdState_t   pfd;

  synthLoopControl #(
    .LOCK_COUNT (LOCK_COUNT),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .currentSel (currentSel),
    .pumpKill   (pumpKill),
    .testRoute  (testRoute),
    .ampKill    (ampKill),
    .pfd        (pfd),
    .ctrl       (ctrl),
    .currentHigh(currentHigh),
    .ampEnable  (ampEnable),
    .lockFlag   (lockFlag)
  );

  synthLoopDatapath #(
    .REF_DIV  (REF_DIV),
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .rfTick   (rfTick),
    .ratio    (ratio),
    .portLatch(portLatch),
    .ctrl     (ctrl),
    .pfd      (pfd),
    .pumpUp   (pumpUp),
    .pumpDown (pumpDown),
    .portP6   (portP6),
    .portP7   (portP7)
  );

  AST_PUMP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pumpKill |-> (!pumpUp && !pumpDown));  // R7

endmodule

// File: tb/synthLoopCore_test.sv
module synthLoopCore_test;

  localparam int LIMIT = 16;
  localparam int LOCKN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b1;
  logic        rfTick = 1'b0;
  logic [14:0] ratio = 15'd100;
  logic        currentSel = 1'b0;
  logic        pumpKill = 1'b0;
  logic        testRoute = 1'b0;
  logic        ampKill = 1'b0;
  logic [1:0]  portLatch = 2'b10;
  logic        pumpUp, pumpDown, currentHigh, ampEnable, lockFlag, portP6, portP7;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rfGap = 0;
  int rfPh = 0;

  // period scoreboard
  int    perQ[$];
  string perTag = "R3";
  bit    p7Watch = 0;
  bit    haveLast = 0;
  bit    p7Prev = 0;
  int    lastRise = 0;

  // lock scoreboard
  bit lockQ[$];
  bit lockWatch = 0;
  int mWc = 0;
  int mGood = 0;
  bit mLock = 0;

  synthLoopCore uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .rfTick(rfTick), .ratio(ratio),
    .currentSel(currentSel), .pumpKill(pumpKill), .testRoute(testRoute),
    .ampKill(ampKill), .portLatch(portLatch), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .currentHigh(currentHigh), .ampEnable(ampEnable), .lockFlag(lockFlag),
    .portP6(portP6), .portP7(portP7)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #4;
  endtask

  task automatic doReset();
    lockWatch = 0;
    rstN = 1'b0;
    rfGap = 0;
    repeat (3) @(negedge clk);
    lockQ.delete();
    mWc = 0; mGood = 0; mLock = 0;
  endtask

  // RF tick generator
  initial begin
    forever begin
      @(negedge clk);
      if (rfGap == 0) begin
        rfTick = 1'b0;
        rfPh = 0;
      end else begin
        rfTick = (rfPh == 0);
        rfPh = (rfPh + 1) % rfGap;
      end
    end
  end

  // Monitor: divided-period scoreboard and lock scoreboard
  initial begin
    forever begin
      settle();
      if (p7Watch) begin
        if (portP7 && !p7Prev) begin
          if (haveLast && perQ.size() > 0) chk(perTag, cyc - lastRise, perQ.pop_front());
          lastRise = cyc;
          haveLast = 1;
        end
      end else begin
        haveLast = 0;
      end
      p7Prev = portP7;

      if (lockWatch && !pumpKill) begin
        if (lockQ.size() > 0) chk("R10 lock", lockFlag, lockQ.pop_front());
        // model from the pump outputs (refTick is high every cycle)
        if (pumpUp && pumpDown) begin
          if (mWc <= LIMIT) begin
            mGood = (mGood + 1 > LOCKN) ? LOCKN : mGood + 1;
            if (mGood == LOCKN) mLock = 1;
          end else begin
            mGood = 0; mLock = 0;
          end
          mWc = 0;
        end else begin
          if (mWc > LIMIT) begin
            mGood = 0; mLock = 0;
          end
          if ((pumpUp || pumpDown) && mWc <= LIMIT) mWc++;
        end
        lockQ.push_back(mLock);
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc == 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int risePt;
    int fallPt;
    // R1 reset state
    repeat (3) @(negedge clk);
    #4;
    chk("R1 pumpUp", pumpUp, 0);
    chk("R1 pumpDown", pumpDown, 0);
    chk("R1 lockFlag", lockFlag, 0);
    chk("R1 portP6", portP6, 0);
    chk("R1 portP7", portP7, 1);

    // R8 decode
    currentSel = 1'b1; ampKill = 1'b0; #1;
    chk("R8 currentHigh", currentHigh, 1);
    chk("R8 ampEnable", ampEnable, 1);
    currentSel = 1'b0; ampKill = 1'b1; #1;
    chk("R8 currentHigh", currentHigh, 0);
    chk("R8 ampEnable", ampEnable, 0);
    ampKill = 1'b0;

    // R6 first comparison event, no RF ticks
    @(negedge clk);
    rstN = 1'b1;
    repeat (511) @(negedge clk);
    #4;
    chk("R6 up before edge", pumpUp, 0);
    settle();
    chk("R6 up after edge", pumpUp, 1);
    chk("R6 down idle", pumpDown, 0);

    // R7 pump kill hides live detector state
    pumpKill = 1'b1; #1;
    chk("R7 up killed", pumpUp, 0);
    chk("R7 down killed", pumpDown, 0);
    pumpKill = 1'b0; #1;
    chk("R7 up restored", pumpUp, 1);

    // R6 one RF tick: both high, then both clear
    rfTick = 1'b1;
    settle();
    chk("R6 both up", pumpUp, 1);
    chk("R6 both down", pumpDown, 1);
    settle();
    chk("R6 cleared up", pumpUp, 0);
    chk("R6 cleared down", pumpDown, 0);

    // R9 route on, R2 comparison waveform on portP6
    testRoute = 1'b1;
    ratio = 15'd100;
    rfGap = 1;
    do settle(); while (!(portP6 === 1'b1 && p7Prev === 1'b0) && portP6 !== 1'b0);
    do settle(); while (portP6 !== 1'b0);
    do settle(); while (portP6 !== 1'b1);
    risePt = cyc;
    do settle(); while (portP6 !== 1'b0);
    fallPt = cyc;
    do settle(); while (portP6 !== 1'b1);
    chk("R2 high time", fallPt - risePt, 256);
    chk("R2 period", cyc - risePt, 512);

    // R3 divided periods on portP7
    repeat (300) @(negedge clk);
    perTag = "R3";
    p7Watch = 1;
    repeat (3) perQ.push_back(100);
    wait (perQ.size() == 0);

    // R4 ratio below the floor
    p7Watch = 0;
    ratio = 15'd3;
    rfGap = 3;
    repeat (400) @(negedge clk);
    perTag = "R4";
    p7Watch = 1;
    repeat (3) perQ.push_back(24);
    wait (perQ.size() == 0);

    // R5 change just after a reload: current period keeps the old ratio
    ratio = 15'd40;
    perTag = "R5";
    perQ.push_back(24);
    perQ.push_back(120);
    perQ.push_back(120);
    wait (perQ.size() == 0);
    p7Watch = 0;

    // R9 route off: pins follow the latch
    settle();
    testRoute = 1'b0;
    portLatch = 2'b01; #1;
    chk("R9 portP6 latch", portP6, 1);
    chk("R9 portP7 latch", portP7, 0);
    portLatch = 2'b10; #1;
    chk("R9 portP6 latch", portP6, 0);
    chk("R9 portP7 latch", portP7, 1);

    // R10 lock with matched rates, then loss with a mismatched ratio
    doReset();
    ratio = 15'd256;
    lockWatch = 1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (508) @(negedge clk);
    rfGap = 2;
    repeat (3600) @(negedge clk);
    #4;
    chk("R10 locked", lockFlag, 1);
    ratio = 15'd250;
    repeat (4000) @(negedge clk);
    #4;
    chk("R10 unlocked", lockFlag, 0);
    lockWatch = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule